// File: doc/BRIEF.md
# Ring Buffer Playback Fetcher

This block walks a circular region of memory one 64-bit word at a time and keeps a local line FIFO stocked for a downstream serializer. Software sets a start address and an inclusive finish address. The finish address names the last word of the ring. Software also sets the usable FIFO capacity, a refill threshold, an enable and a load control. The block issues single-word reads on a simple request/response port. It pushes each returned word into the FIFO, and the consumer pops words in the order they were fetched.

To start playback, raise the load control and then raise enable. The 0-to-1 edge of load places the fetch pointer at the start address. A read-back of the pointer's distance from the start address shows how far playback has advanced in the ring. Clearing enable halts fetching and empties the FIFO.

Top module: `ring_fetch`

## Requirements
- R1: Words leave the FIFO in the order their read responses arrived. `fifo_data` shows the oldest stored word whenever `fifo_empty` is 0. A `pop` while `fifo_empty` is 1 is ignored.
- R2: The first request after a load edge uses the start address. Each accepted request (`mem_req_valid` and `mem_req_ready` both high) advances the pointer by 8. After the request at the finish address is accepted, the next one goes back to the start address.
- R3: When the start and finish addresses are equal, every request carries that one address.
- R4: At most one read is outstanding. After a request is accepted, `mem_req_valid` stays low until `mem_rsp_valid` has been seen.
- R5: A request is raised only when enable is 1, no read is outstanding, the stored level is at most `cfg_thresh_m1`, and the level is at most `cfg_depth_m1`. The capacity is therefore `cfg_depth_m1`+1 lines.
- R6: `pos_offset` equals the current pointer minus `cfg_start_addr`, modulo 2^32.
- R7: The pointer reloads from the start address only in the cycle after `cfg_load` goes from 0 to 1. Holding `cfg_load` at 1 causes no further reloads.
- R8: While `cfg_enable` is 0, no request is raised, and the FIFO is empty from the next cycle on. A response that arrives while `cfg_enable` is 0 is discarded. It still ends the outstanding read.
- R9: After reset, the FIFO is empty, no request is raised and the pointer is 0.
- R10: A request held with `mem_req_ready` low keeps `mem_req_valid` high and its address unchanged. This holds while enable stays 1 and no load edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_addr | input | 32 | Byte address of the first ring word |
| cfg_finish_addr | input | 32 | Byte address of the last ring word (inclusive) |
| cfg_depth_m1 | input | CFG_W | Usable FIFO lines minus one |
| cfg_thresh_m1 | input | CFG_W | Refill threshold in lines minus one |
| cfg_enable | input | 1 | Fetch enable; low flushes the FIFO |
| cfg_load | input | 1 | Pointer reload on a rising edge |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 32 | Read request byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data word |
| pop | input | 1 | Consumer takes the head word |
| fifo_data | output | 64 | Head word of the FIFO |
| fifo_empty | output | 1 | FIFO holds no word |
| pos_offset | output | 32 | Current pointer minus start address |

## Verification
Two situations are hard to reach from the ports. One is a stale response: a read that was accepted and is still in flight when enable is dropped. It must end the outstanding state without landing in the flushed FIFO. The bench reaches it by giving the memory model a six-cycle latency and clearing enable during continuous refilling. The other is a request held across several not-ready cycles while the consumer pops. The memory model's acceptance pattern produces this, and a behavioural reference compared every cycle covers the wrap, threshold and capacity limits across several ring shapes. One of those rings sits at the top of the 32-bit address space.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 64;
    localparam logic [ADDR_W-1:0] LINE_BYTES = 32'd8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    // pointer walker state
    typedef struct packed {
        addr_t ptr;
        logic  load_prev;
        logic  busy;
    } walk_t;
endpackage

// File: rtl/rf_walker.sv
module rf_walker
    import rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t start_addr,
    input  addr_t finish_addr,
    input  logic  load,
    input  logic  issue,
    input  logic  rsp_valid,
    output addr_t ptr,
    output logic  busy
);
    walk_t s_d, s_q;
    logic  load_rise;

    always_comb begin
        s_d       = s_q;
        load_rise = load && !s_q.load_prev;
        s_d.load_prev = load;
        if (load_rise) begin
            s_d.ptr = start_addr;
        end else if (issue) begin
            s_d.ptr = (s_q.ptr == finish_addr) ? start_addr : s_q.ptr + LINE_BYTES;
        end
        if (issue) begin
            s_d.busy = 1'b1;
        end else if (rsp_valid) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr  = s_q.ptr;
    assign busy = s_q.busy;
endmodule

// File: rtl/rf_line_fifo.sv
module rf_line_fifo
    import rf_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IW = $clog2(LINES),
    localparam int LW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  word_t         wdata,
    input  logic          pop,
    output word_t         rdata,
    output logic          empty,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [IW-1:0] wr;
        logic [IW-1:0] rd;
        logic [LW-1:0] cnt;
    } fst_t;

    fst_t  s_d, s_q;
    word_t store [LINES];
    logic  do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0) && !flush;
        do_push = push && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr = s_q.wr + 1'b1;
            if (do_pop)  s_d.rd = s_q.rd + 1'b1;
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[s_q.wr] <= wdata;
    end

    assign rdata = store[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign level = s_q.cnt;
endmodule

// File: rtl/rf_policy.sv
module rf_policy #(
    parameter int CFG_W = 4,
    localparam int LW = CFG_W + 1
) (
    input  logic             enable,
    input  logic             busy,
    input  logic [LW-1:0]    level,
    input  logic [CFG_W-1:0] thresh_m1,
    input  logic [CFG_W-1:0] depth_m1,
    output logic             want
);
    logic below_thresh, has_room;

    always_comb begin
        below_thresh = level <= {1'b0, thresh_m1};
        has_room     = level <= {1'b0, depth_m1};
        want         = enable && !busy && below_thresh && has_room;
    end
endmodule

// File: rtl/ring_fetch.sv
module ring_fetch
    import rf_pkg::*;
#(
    parameter int MAX_LINES = 16,
    localparam int CFG_W = $clog2(MAX_LINES),
    localparam int LW = CFG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_start_addr,
    input  logic [31:0]      cfg_finish_addr,
    input  logic [CFG_W-1:0] cfg_depth_m1,
    input  logic [CFG_W-1:0] cfg_thresh_m1,
    input  logic             cfg_enable,
    input  logic             cfg_load,
    output logic             mem_req_valid,
    output logic [31:0]      mem_req_addr,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    input  logic             pop,
    output logic [63:0]      fifo_data,
    output logic             fifo_empty,
    output logic [31:0]      pos_offset
);
    addr_t         cur_ptr;
    logic          busy;
    logic          want;
    logic          issue;
    logic          push;
    logic [LW-1:0] level;

    assign issue = want && mem_req_ready;
    assign push  = mem_rsp_valid && busy && cfg_enable;

    rf_walker u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_addr  (cfg_start_addr),
        .finish_addr (cfg_finish_addr),
        .load        (cfg_load),
        .issue       (issue),
        .rsp_valid   (mem_rsp_valid),
        .ptr         (cur_ptr),
        .busy        (busy)
    );

    rf_policy #(.CFG_W(CFG_W)) u_pol (
        .enable    (cfg_enable),
        .busy      (busy),
        .level     (level),
        .thresh_m1 (cfg_thresh_m1),
        .depth_m1  (cfg_depth_m1),
        .want      (want)
    );

    rf_line_fifo #(.LINES(MAX_LINES)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!cfg_enable),
        .push  (push),
        .wdata (mem_rsp_data),
        .pop   (pop),
        .rdata (fifo_data),
        .empty (fifo_empty),
        .level (level)
    );

    assign mem_req_valid = want;
    assign mem_req_addr  = cur_ptr;
    assign pos_offset    = cur_ptr - cfg_start_addr;
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int CFG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      cfg_start_addr,
    input logic [CFG_W-1:0] cfg_depth_m1,
    input logic [CFG_W-1:0] cfg_thresh_m1,
    input logic             cfg_enable,
    input logic             cfg_load,
    input logic             mem_req_valid,
    input logic [31:0]      mem_req_addr,
    input logic             mem_req_ready,
    input logic             mem_rsp_valid,
    input logic             fifo_empty,
    input logic [31:0]      pos_offset
);
    logic pend_q, lp_q, rise;

    assign rise = cfg_load && !lp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            lp_q   <= 1'b0;
        end else begin
            lp_q <= cfg_load;
            if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
            else if (mem_rsp_valid)             pend_q <= 1'b0;
        end
    end

    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid);

    a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> cfg_enable);

    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> fifo_empty);

    a_r7_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (pos_offset == 32'd0 || !$stable(cfg_start_addr)));

    a_r2_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !rise) |=>
            (!$stable(cfg_start_addr) || pos_offset == $past(pos_offset) + 32'd8
             || pos_offset == 32'd0));

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !rise) |=>
            (!cfg_enable || !$stable(cfg_thresh_m1) || !$stable(cfg_depth_m1)
             || (mem_req_valid && $stable(mem_req_addr))));
endmodule

bind ring_fetch rf_checker #(.CFG_W(CFG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start_addr (cfg_start_addr),
    .cfg_depth_m1   (cfg_depth_m1),
    .cfg_thresh_m1  (cfg_thresh_m1),
    .cfg_enable     (cfg_enable),
    .cfg_load       (cfg_load),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_req_ready  (mem_req_ready),
    .mem_rsp_valid  (mem_rsp_valid),
    .fifo_empty     (fifo_empty),
    .pos_offset     (pos_offset)
);

// File: tb/tb_ring_fetch.sv
module tb_ring_fetch;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_start_addr = '0, cfg_finish_addr = '0;
    logic [CW-1:0] cfg_depth_m1 = '0, cfg_thresh_m1 = '0;
    logic          cfg_enable = 1'b0, cfg_load = 1'b0;
    logic          mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0]   mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [63:0]   mem_rsp_data = '0;
    logic          pop = 1'b0;
    logic [63:0]   fifo_data;
    logic          fifo_empty;
    logic [31:0]   pos_offset;

    always #10 clk = ~clk;

    ring_fetch dut (.*);

    int total = 0, bad = 0, cyc = 0;
    int lat = 0, rdy_mode = 0;

    // reference model state
    logic [31:0] m_ptr = '0;
    bit          m_lp = 0, m_busy = 0;
    logic [63:0] q[$];

    // memory model state
    bit          pend = 0;
    int          dly = 0;
    logic [31:0] paddr = '0;
    bit          prev_wait = 0;
    logic [31:0] prev_addr = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] word_of(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a};
    endfunction

    function automatic bit m_req();
        return cfg_enable && !m_busy && (q.size() <= int'(cfg_thresh_m1))
               && (q.size() <= int'(cfg_depth_m1));
    endfunction

    // reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = '0; m_lp = 0; m_busy = 0; q.delete();
        end else begin
            bit iss, rise, popq, pushq;
            iss   = m_req() && mem_req_ready;
            rise  = cfg_load && !m_lp;
            popq  = pop && (q.size() > 0);
            pushq = mem_rsp_valid && m_busy && cfg_enable;
            if (rise) m_ptr = cfg_start_addr;
            else if (iss) m_ptr = (m_ptr == cfg_finish_addr) ? cfg_start_addr : m_ptr + 32'd8;
            m_lp = cfg_load;
            if (iss) m_busy = 1;
            else if (mem_rsp_valid) m_busy = 0;
            if (!cfg_enable) q.delete();
            else begin
                if (popq) void'(q.pop_front());
                if (pushq) q.push_back(mem_rsp_data);
            end
        end
    end

    // compare and memory model
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (!rst_n) begin
            pend = 0; mem_rsp_valid = 0; mem_req_ready = 0; prev_wait = 0;
        end else begin
            chk(mem_req_valid === m_req(), "R5 request gate", 64'(mem_req_valid), 64'(m_req()));
            chk(!(m_busy && mem_req_valid), "R4 one outstanding", 64'(mem_req_valid), 64'd0);
            if (mem_req_valid && m_req())
                chk(mem_req_addr === m_ptr, "R2 address", 64'(mem_req_addr), 64'(m_ptr));
            chk(pos_offset === m_ptr - cfg_start_addr, "R6 offset", 64'(pos_offset),
                64'(m_ptr - cfg_start_addr));
            chk(fifo_empty === (q.size() == 0), "R8 empty flag", 64'(fifo_empty), 64'(q.size() == 0));
            if (q.size() > 0 && !fifo_empty)
                chk(fifo_data === q[0], "R1 head data", fifo_data, q[0]);
            if (prev_wait && cfg_enable)
                chk(mem_req_valid && mem_req_addr === prev_addr, "R10 held request",
                    64'(mem_req_addr), 64'(prev_addr));
            // memory response
            mem_rsp_valid = 0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1; mem_rsp_data = word_of(paddr); pend = 0;
                end else dly--;
            end
            case (rdy_mode)
                0:       mem_req_ready = 1'b1;
                1:       mem_req_ready = cyc[0];
                default: mem_req_ready = (cyc % 4 == 3);
            endcase
            if (mem_req_valid && mem_req_ready) begin
                pend = 1; paddr = mem_req_addr; dly = lat;
            end
            prev_wait = mem_req_valid && !mem_req_ready && !(cfg_load && !m_lp);
            prev_addr = mem_req_addr;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic start_ring(input logic [31:0] s, input logic [31:0] f,
                              input logic [CW-1:0] d, input logic [CW-1:0] t);
        cfg_enable = 0; cfg_load = 0;
        step(2);
        cfg_start_addr = s; cfg_finish_addr = f; cfg_depth_m1 = d; cfg_thresh_m1 = t;
        cfg_load = 1;
        step(1);
        cfg_enable = 1;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        @(negedge clk); #1;
        // R9 reset state
        chk(fifo_empty === 1'b1, "R9 reset empty", 64'(fifo_empty), 64'd1);
        chk(mem_req_valid === 1'b0, "R9 reset no request", 64'(mem_req_valid), 64'd0);
        chk(pos_offset === 32'd0, "R9 reset pointer", 64'(pos_offset), 64'd0);

        // threshold fill, no consumer
        lat = 0; rdy_mode = 0;
        start_ring(32'h1000, 32'h1038, 4'd7, 4'd3);
        step(20);
        chk(mem_req_valid === 1'b0, "R5 threshold reached", 64'(mem_req_valid), 64'd0);
        chk(fifo_empty === 1'b0, "R1 words stored", 64'(fifo_empty), 64'd0);

        // streaming with wraps; load held high
        lat = 2; rdy_mode = 1;
        begin
            bit moved = 0;
            for (int i = 0; i < 300; i++) begin
                pop = (i % 3 != 0);
                step(1);
                if (pos_offset != 32'd0) moved = 1;
            end
            chk(moved, "R7 held load no reload", 64'(moved), 64'd1);
        end
        pop = 0;
        cfg_load = 0;
        step(1);
        cfg_load = 1;
        step(1);
        chk(pos_offset === 32'd0, "R7 edge reload", 64'(pos_offset), 64'd0);

        // disable with a read in flight
        lat = 6; rdy_mode = 0; pop = 1;
        step(23);
        cfg_enable = 0;
        step(1);
        chk(fifo_empty === 1'b1, "R8 flush on disable", 64'(fifo_empty), 64'd1);
        chk(mem_req_valid === 1'b0, "R8 no request disabled", 64'(mem_req_valid), 64'd0);
        step(4);
        cfg_enable = 1;
        step(12);
        pop = 0;

        // single-word ring
        lat = 1; rdy_mode = 2;
        start_ring(32'h2000, 32'h2000, 4'd7, 4'd3);
        pop = 1;
        for (int i = 0; i < 120; i++) begin
            step(1);
            if (mem_req_valid)
                chk(mem_req_addr === 32'h2000, "R3 single word", 64'(mem_req_addr), 64'h2000);
        end
        pop = 0;

        // small capacity at the top of the address space
        lat = 0; rdy_mode = 0;
        start_ring(32'hFFFF_FFF0, 32'hFFFF_FFF8, 4'd1, 4'd7);
        step(20);
        chk(mem_req_valid === 1'b0, "R5 room limit", 64'(mem_req_valid), 64'd0);
        for (int i = 0; i < 100; i++) begin
            pop = i[0];
            step(1);
        end
        pop = 0;

        // deep ring, slow memory
        lat = 3; rdy_mode = 2;
        start_ring(32'h4000, 32'h40F8, 4'd15, 4'd15);
        for (int i = 0; i < 400; i++) begin
            pop = (i % 5 == 0);
            step(1);
        end
        pop = 1;
        step(40);
        cfg_enable = 0;
        step(10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule